// File: doc/BRIEF.md
# ADC conversion sequencer with selection lock

This block sequences the timing of a successive-approximation analog-to-digital conversion. The analog part is outside the block. The sequencer sends it a one-clock sample-and-hold strobe and captures its result word when the conversion ends. Time is counted in half ADC clock cycles. A clock-enable input marks each half cycle and runs at twice the ADC clock rate, so the half-cycle sample points are reached exactly. The enable pulses alternate between rising and falling ADC edges, and the first one after reset is a rising edge.

Software writes a channel/reference selection register. A second register holds the copy that actually drives the analog multiplexer. While the converter is idle, the copy follows the written value. From the start of a conversion the copy is frozen, so the sample is taken on a steady input. In the last ADC cycle before completion it follows the written value again, so a value written during a conversion takes effect for the next one.

A conversion starts in one of two ways. A software start waits for the next rising ADC edge. An auto-trigger event, when enabled, starts a conversion on the next half-cycle tick. The first conversion after the converter is enabled uses a longer timing. Later conversions use normal timing if started by software and auto-trigger timing if started by a trigger.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `mux_sel`, `result`, `done_flag`, `start_busy` and `sh_strobe` are all zero.
- R2: While no conversion runs, `mux_sel` equals the value given with `sel_wr` from the second clock edge after the write.
- R3: A software start (`start_wr` while `adc_en` is 1) begins on the first rising-edge tick after the write. Ticks are numbered 0, 1, 2, ... from reset, and even-numbered ticks are rising edges. The write's own clock edge never counts as that start tick.
- R4: The first conversion after `adc_en` goes from 0 to 1 pulses `sh_strobe` 27 ticks after its start tick and sets `done_flag` 50 ticks after it (13.5 and 25 ADC cycles).
- R5: A software-started conversion that is not the first pulses `sh_strobe` 3 ticks after start and completes 26 ticks after start (1.5 and 13 ADC cycles).
- R6: A trigger pulse on `trig` while `adc_en` and `auto_en` are 1 and the converter is idle starts a conversion on the next tick, whatever its phase. That conversion, if it is not the first, pulses `sh_strobe` 4 ticks after start and completes 27 ticks after start (2 and 13.5 ADC cycles).
- R7: From the start tick until 2 ticks before completion, `mux_sel` does not change, even if the selection register is written. A value written in that window drives `mux_sel` by the time `done_flag` rises.
- R8: On completion, `done_flag` rises and, on the same clock edge, `result` takes the `conv_data` value present at the completing tick. `flag_clr` clears `done_flag`; a completion in the same clock wins over the clear.
- R9: `start_busy` reads 1 from the clock edge after a start write (or after a trigger start) until completion. It is 0 after completion.
- R10: A trigger arriving while a conversion is busy is ignored: no further strobe or conversion follows it.
- R11: Only the first conversion after each enable uses the R4 timing. The next one uses R5 or R6 timing.
- R12: Taking `adc_en` low during a conversion aborts it: `start_busy` drops, and no strobe or completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Half-ADC-cycle clock enable |
| adc_en | input | 1 | Converter enable |
| auto_en | input | 1 | Auto-trigger enable |
| start_wr | input | 1 | Software start write pulse |
| trig | input | 1 | Auto-trigger event pulse |
| sel_wr | input | 1 | Selection register write strobe |
| sel_wdata | input | SEL_W | Selection value to write |
| flag_clr | input | 1 | Clears the completion flag |
| conv_data | input | RES_W | Result word from the analog converter |
| mux_sel | output | SEL_W | Buffered selection driving the multiplexer |
| sh_strobe | output | 1 | One-clock sample-and-hold pulse |
| start_busy | output | 1 | Start bit readback, 1 while a conversion is pending or running |
| done_flag | output | 1 | Sticky completion flag |
| result | output | RES_W | Captured conversion result |

## Verification
The bench varies where the start write falls relative to the ADC clock phase. A design that starts on the write itself, or on a falling edge, would move the strobe and the completion by one tick. It also moves the trigger across both tick phases, so the 2-cycle and 13.5-cycle points are checked for both. It writes the selection during a running conversion and checks that `mux_sel` holds up to 2 ticks before the end, then changes by completion. A design that never froze the copy, or never let it follow again, would fail there. Retriggering while busy, aborting through the enable, and re-enabling are all covered. A design that queued the trigger or lost track of the first-conversion flag would give an extra conversion or the wrong length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    KIND_FIRST  = 2'd0,
    KIND_NORMAL = 2'd1,
    KIND_AUTO   = 2'd2
  } conv_kind_e;
endpackage

// File: rtl/adc_seq_phase.sv
// Tracks which ADC edge each half-cycle tick represents.
module adc_seq_phase (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic rise_tick
);
  logic phase_q;  // 0: next tick is a rising ADC edge

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
    end else if (tick_en) begin
      phase_q <= ~phase_q;
    end
  end

  assign rise_tick = tick_en & ~phase_q;
endmodule

// File: rtl/adc_seq_fsm.sv
// Conversion timer: start arbitration, half-tick counter, strobes.
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int FIRST_LEN = 50,
  parameter int FIRST_SH  = 27,
  parameter int NORM_LEN  = 26,
  parameter int NORM_SH   = 3,
  parameter int AUTO_LEN  = 27,
  parameter int AUTO_SH   = 4,
  parameter int CNT_W     = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic rise_tick,
  input  logic adc_en,
  input  logic auto_en,
  input  logic start_wr,
  input  logic trig,
  output logic busy,
  output logic start_bit,
  output logic lock,
  output logic sh_pulse,
  output logic cmpl
);
  logic             en_q;
  logic             first_q;
  logic             trig_pend;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] len_sel;
  logic [CNT_W-1:0] sh_sel;
  conv_kind_e       kind_q;
  logic             go_trig;
  logic             go_sw;
  logic             go;

  assign go_trig = adc_en & tick_en & trig_pend & ~busy;
  assign go_sw   = adc_en & rise_tick & start_bit & ~busy & ~trig_pend;
  assign go      = go_trig | go_sw;
  assign nxt     = cnt + CNT_W'(1);

  always_comb begin
    case (kind_q)
      KIND_FIRST: begin
        len_sel = CNT_W'(FIRST_LEN);
        sh_sel  = CNT_W'(FIRST_SH);
      end
      KIND_AUTO: begin
        len_sel = CNT_W'(AUTO_LEN);
        sh_sel  = CNT_W'(AUTO_SH);
      end
      default: begin
        len_sel = CNT_W'(NORM_LEN);
        sh_sel  = CNT_W'(NORM_SH);
      end
    endcase
  end

  assign cmpl     = adc_en & busy & tick_en & (nxt == len_sel);
  assign sh_pulse = adc_en & busy & tick_en & (nxt == sh_sel);
  assign lock     = busy & (cnt < (len_sel - CNT_W'(2)));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      first_q   <= 1'b0;
      trig_pend <= 1'b0;
      start_bit <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      kind_q    <= KIND_NORMAL;
    end else begin
      en_q <= adc_en;

      if (adc_en && !en_q) begin
        first_q <= 1'b1;
      end else if (cmpl) begin
        first_q <= 1'b0;
      end

      if (!adc_en || !auto_en || go) begin
        trig_pend <= 1'b0;
      end else if (trig && !busy) begin
        trig_pend <= 1'b1;
      end

      if (!adc_en || cmpl) begin
        start_bit <= 1'b0;
      end else if (start_wr || go_trig) begin
        start_bit <= 1'b1;
      end

      if (!adc_en || cmpl) begin
        busy <= 1'b0;
      end else if (go) begin
        busy <= 1'b1;
      end

      if (go) begin
        cnt <= '0;
        if (first_q) begin
          kind_q <= KIND_FIRST;
        end else if (go_trig) begin
          kind_q <= KIND_AUTO;
        end else begin
          kind_q <= KIND_NORMAL;
        end
      end else if (busy && tick_en) begin
        cnt <= nxt;
      end
    end
  end
endmodule

// File: rtl/adc_seq_selbuf.sv
// Selection register plus the lockable copy that drives the multiplexer.
module adc_seq_selbuf #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             lock,
  output logic [SEL_W-1:0] mux_sel
);
  logic [SEL_W-1:0] sel_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_reg <= '0;
      mux_sel <= '0;
    end else begin
      if (sel_wr) begin
        sel_reg <= sel_wdata;
      end
      if (!lock) begin
        mux_sel <= sel_reg;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int SEL_W     = 5,
  parameter int RES_W     = 10,
  parameter int FIRST_LEN = 50,
  parameter int FIRST_SH  = 27,
  parameter int NORM_LEN  = 26,
  parameter int NORM_SH   = 3,
  parameter int AUTO_LEN  = 27,
  parameter int AUTO_SH   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             adc_en,
  input  logic             auto_en,
  input  logic             start_wr,
  input  logic             trig,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] conv_data,
  output logic [SEL_W-1:0] mux_sel,
  output logic             sh_strobe,
  output logic             start_busy,
  output logic             done_flag,
  output logic [RES_W-1:0] result
);
  localparam int MAX_A = (FIRST_LEN > NORM_LEN) ? FIRST_LEN : NORM_LEN;
  localparam int MAX_L = (MAX_A > AUTO_LEN) ? MAX_A : AUTO_LEN;
  localparam int CNT_W = $clog2(MAX_L + 1);

  logic rise_tick;
  logic busy;
  logic lock;
  logic sh_pulse;
  logic cmpl;

  adc_seq_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .rise_tick (rise_tick)
  );

  adc_seq_fsm #(
    .FIRST_LEN (FIRST_LEN),
    .FIRST_SH  (FIRST_SH),
    .NORM_LEN  (NORM_LEN),
    .NORM_SH   (NORM_SH),
    .AUTO_LEN  (AUTO_LEN),
    .AUTO_SH   (AUTO_SH),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .rise_tick (rise_tick),
    .adc_en    (adc_en),
    .auto_en   (auto_en),
    .start_wr  (start_wr),
    .trig      (trig),
    .busy      (busy),
    .start_bit (start_busy),
    .lock      (lock),
    .sh_pulse  (sh_pulse),
    .cmpl      (cmpl)
  );

  adc_seq_selbuf #(
    .SEL_W (SEL_W)
  ) u_selbuf (
    .clk       (clk),
    .rst       (rst),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .lock      (lock),
    .mux_sel   (mux_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_strobe <= 1'b0;
      done_flag <= 1'b0;
      result    <= '0;
    end else begin
      sh_strobe <= sh_pulse;
      if (cmpl) begin
        done_flag <= 1'b1;
        result    <= conv_data;
      end else if (flag_clr) begin
        done_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int SEL_W = 5,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_en,
  input logic [RES_W-1:0] conv_data,
  input logic [SEL_W-1:0] mux_sel,
  input logic             sh_strobe,
  input logic             start_busy,
  input logic             done_flag,
  input logic [RES_W-1:0] result,
  input logic             busy,
  input logic             lock
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done_flag && !start_busy && !sh_strobe));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(mux_sel));

  // R8
  result_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> (result == $past(conv_data)));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(start_busy) |-> (done_flag || !$past(adc_en)));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    sh_strobe |=> !sh_strobe);

  // R12
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sh_strobe) |-> $past(busy));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.SEL_W(SEL_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .adc_en     (adc_en),
  .conv_data  (conv_data),
  .mux_sel    (mux_sel),
  .sh_strobe  (sh_strobe),
  .start_busy (start_busy),
  .done_flag  (done_flag),
  .result     (result),
  .busy       (busy),
  .lock       (lock)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int SEL_W = 5;
  localparam int RES_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             adc_en = 1'b0;
  logic             auto_en = 1'b0;
  logic             start_wr = 1'b0;
  logic             trig = 1'b0;
  logic             sel_wr = 1'b0;
  logic [SEL_W-1:0] sel_wdata = '0;
  logic             flag_clr = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic [SEL_W-1:0] mux_sel;
  logic             sh_strobe;
  logic             start_busy;
  logic             done_flag;
  logic [RES_W-1:0] result;
  logic             tick_en;

  int checks = 0;
  int fails = 0;
  int clk_cnt = 0;
  int ticks_seen = 0;
  int sh_tick = -1;
  int sh_count = 0;
  int done_tick = -1;
  logic done_prev = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .adc_en(adc_en),
    .auto_en(auto_en), .start_wr(start_wr), .trig(trig), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .flag_clr(flag_clr), .conv_data(conv_data),
    .mux_sel(mux_sel), .sh_strobe(sh_strobe), .start_busy(start_busy),
    .done_flag(done_flag), .result(result)
  );

  assign tick_en = (clk_cnt % 4) == 3;

  always @(posedge clk) begin
    clk_cnt <= clk_cnt + 1;
    if (rst) ticks_seen <= 0;
    else if (tick_en) ticks_seen <= ticks_seen + 1;
  end

  always @(negedge clk) begin
    if (sh_strobe) begin
      sh_tick  = ticks_seen;
      sh_count = sh_count + 1;
    end
    if (done_flag && !done_prev) done_tick = ticks_seen;
    done_prev = done_flag;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clocks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic to_quiet_clock();
    @(negedge clk);
    while (tick_en) @(negedge clk);
  endtask

  task automatic write_sel(logic [SEL_W-1:0] v);
    @(negedge clk);
    sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    sh_tick = -1; done_tick = -1;
  endtask

  task automatic wait_done(int limit);
    for (int i = 0; i < limit && done_tick < 0; i++) @(negedge clk);
  endtask

  // software start; returns start tick index
  task automatic sw_start(output int s);
    int t;
    to_quiet_clock();
    t = ticks_seen;
    s = t + (t % 2);
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  task automatic trig_start(output int s);
    to_quiet_clock();
    s = ticks_seen;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic run_sw(string req, int shp, int len, logic [RES_W-1:0] d);
    int s;
    clear_flag();
    conv_data = d;
    sw_start(s);
    check({req, " start_busy"}, start_busy, 1);  // R9
    wait_done(4 * len + 40);
    check({req, " sh tick"}, sh_tick, s + shp + 1);
    check({req, " done tick"}, done_tick, s + len + 1);
    check({req, " result"}, result, d);
    check({req, " start_busy clear"}, start_busy, 0);
  endtask

  initial begin
    int s;
    clocks(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mux_sel", mux_sel, 0);
    check("R1 result", result, 0);
    check("R1 done_flag", done_flag, 0);
    check("R1 start_busy", start_busy, 0);
    check("R1 sh_strobe", sh_strobe, 0);

    // R2 sweep of selection tracking while idle
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      sel_wr = 1'b1; sel_wdata = SEL_W'(v);
      @(negedge clk);
      sel_wr = 1'b0;
      @(negedge clk);
      check("R2 mux follows", mux_sel, v);
    end

    // R4 and R11 first conversion after enable
    adc_en = 1'b1;
    clocks(3);
    run_sw("R4 first", 27, 50, 10'h2A5);

    // R3 and R5 normal conversions over start offsets
    for (int off = 0; off < 8; off++) begin
      clocks(off);
      run_sw("R3 R5 normal", 3, 26, RES_W'(off * 37 + 5));
    end

    // R8 flag clear
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R8 flag cleared", done_flag, 0);

    // R7 lock during conversion
    write_sel(5'd9);
    clocks(2);
    clear_flag();
    sw_start(s);
    clocks(12);
    write_sel(5'd22);
    while (ticks_seen < s + 26 - 2) @(negedge clk);
    check("R7 held", mux_sel, 9);
    wait_done(200);
    check("R7 released", mux_sel, 22);

    // R6 auto-triggered over both phases
    auto_en = 1'b1;
    for (int off = 0; off < 6; off++) begin
      clear_flag();
      clocks(off);
      conv_data = RES_W'(off * 91 + 3);
      trig_start(s);
      wait_done(200);
      check("R6 sh tick", sh_tick, s + 4 + 1);
      check("R6 done tick", done_tick, s + 27 + 1);
      check("R6 result", result, off * 91 + 3);
    end

    // R10 trigger while busy ignored
    clear_flag();
    trig_start(s);
    clocks(30);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    wait_done(200);
    check("R10 done tick", done_tick, s + 27 + 1);
    sh_count = 0;
    clocks(4 * 40);
    check("R10 no extra strobe", sh_count, 0);
    check("R10 idle", start_busy, 0);

    // R12 abort by disable
    auto_en = 1'b0;
    clear_flag();
    sw_start(s);
    clocks(20);
    adc_en = 1'b0;
    clocks(2);
    check("R12 start_busy dropped", start_busy, 0);
    sh_count = 0;
    clocks(4 * 60);
    check("R12 no completion", done_flag, 0);
    check("R12 no strobe", sh_count, 0);

    // R11 re-enable: first timing once, then normal
    adc_en = 1'b1;
    clocks(3);
    run_sw("R11 first again", 27, 50, 10'h155);
    run_sw("R11 normal after", 3, 26, 10'h0F0);

    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule